// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block collects sixteen level-sensitive interrupt requests and four machine-check requests and signals the processor on dedicated lines. The sixteen requests form two ranking groups of eight slots each. Group A holds eight on-chip sources. Group B holds four on-chip and four off-chip sources. Each source has a mask bit. Each group has a programmable slot map that places its sources into priority slots. A global ordering bit decides which group leads when the two groups are compared. The scheme bit of the trailing group decides whether its slots rank wholly below the leading group or alternate with the leading group's slots.

Slots 0 and 1 of each group can be diverted from the normal interrupt line to the critical line or to the system-management line. For the highest-ranked request that still uses the normal line, the block outputs a vector number equal to its source index plus one. A vector of zero means nothing is pending. The machine-check requests cannot be masked. Any one of them drives a separate output.

Configuration goes through a flat address/write-enable/data port with a combinational read-back. All core-facing outputs are registered.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: Mask register at address 0 holds one bit per source, and 1 masks that source. It resets to all ones. A masked source never raises irqNormal, irqCritical or irqSysMgmt and never appears as the vector.
- R2: Each active request (pending and unmasked) drives exactly one line. For slots 0 and 1 of a group, the 2-bit route code selects the line: 00 or 11 selects normal, 01 selects critical, 10 selects system-management. Slots 2 to 7 always use the normal line. irqCritical and irqSysMgmt are the OR of all active requests routed to them.
- R3: Slot maps sit at address 1 (group A) and address 2 (group B). Bits [3p+2:3p] name the in-group source that occupies slot p. Inside a group, slot 0 ranks highest. Both maps reset to the identity map (slot p holds source p).
- R4: Group A sources are indices 0 to 7 (srcIntA). Group B sources are indices 8 to 11 (srcIntB) and 12 to 15 (srcExtB). Both groups are ranked by the same mechanism.
- R5: Control register (address 3), bit 2, selects the leading group: 0 means group A leads, 1 means group B leads.
- R6: Control bit 0 is group A's scheme and bit 1 is group B's scheme (0 grouped, 1 spread). Only the trailing group's bit has an effect. If the trailing group is grouped, all of its slots rank below every slot of the leading group. If it is spread, its slot p ranks just below the leading slot p and above the leading slot p+1.
- R7: irqVector equals the source index plus one of the highest-ranked active normal-routed request, or 0 if there is none. irqNormal is high exactly when irqVector is nonzero.
- R8: machineCheck is high exactly when at least one mcSrc bit was high at the previous edge, whatever the mask.
- R9: Outputs update on the first clock edge after a request change. A configuration write takes effect at its edge, so the outputs reflect it after the edge that follows.
- R10: Control register layout: route codes for group A slots 0 and 1 at bits [4:3] and [6:5]; for group B slots 0 and 1 at [8:7] and [10:9]. Address 4 reads the raw unmasked requests (bit i = source i). Addresses 5 to 7 read zero. Registers read back what was written.
- R11: After reset, all request outputs are low, irqVector is 0 and the control register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcIntA | input | 8 | Group A on-chip requests, sources 0-7 |
| srcIntB | input | 4 | Group B on-chip requests, sources 8-11 |
| srcExtB | input | 4 | Group B off-chip requests, sources 12-15 |
| mcSrc | input | 4 | Unmaskable machine-check requests |
| cfgAddr | input | 3 | Configuration register address |
| cfgWe | input | 1 | Configuration write enable |
| cfgWdata | input | 24 | Configuration write data |
| cfgRdata | output | 24 | Configuration read data (combinational) |
| irqNormal | output | 1 | Normal interrupt request |
| irqCritical | output | 1 | Critical interrupt request |
| irqSysMgmt | output | 1 | System-management interrupt request |
| irqVector | output | 5 | Vector of the winning normal request, 0 if none |
| machineCheck | output | 1 | Machine-check request |

## Verification
A request change reaches irqNormal, irqCritical, irqSysMgmt, irqVector and machineCheck after one edge. The bench drives inputs on a falling edge and compares on the next falling edge. A configuration write needs one extra edge before it shows, because its register is loaded first. The bench checks that the old value still holds at the first falling edge after the write and that the new value appears at the second. Read-back is combinational, so it is compared on the falling edge just after the address is set.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  localparam int GROUP_SLOTS = 8;
  localparam int NUM_GROUPS  = 2;
  localparam int SLOT_W      = $clog2(GROUP_SLOTS);
  localparam int NUM_SRC     = GROUP_SLOTS * NUM_GROUPS;
  localparam int MIX_INT     = GROUP_SLOTS / 2;
  localparam int MIX_EXT     = GROUP_SLOTS - MIX_INT;
  localparam int MC_SRC      = 4;
  localparam int VEC_W       = $clog2(NUM_SRC + 1);
  localparam int MAP_W       = GROUP_SLOTS * SLOT_W;
  localparam int KEY_W       = $clog2(4 * GROUP_SLOTS);
  localparam int ROUTE_W     = 2;
  localparam int LEAD_BIT    = NUM_GROUPS;
  localparam int ROUTE_LSB   = NUM_GROUPS + 1;
  localparam int CTRL_W      = ROUTE_LSB + NUM_GROUPS * 2 * ROUTE_W;
  localparam int CFG_AW      = 3;
  localparam int CFG_DW      = MAP_W;

  localparam logic [CFG_AW-1:0] ADDR_MASK = 3'd0;
  localparam logic [CFG_AW-1:0] ADDR_MAPA = 3'd1;
  localparam logic [CFG_AW-1:0] ADDR_MAPB = 3'd2;
  localparam logic [CFG_AW-1:0] ADDR_CTRL = 3'd3;
  localparam logic [CFG_AW-1:0] ADDR_PEND = 3'd4;

  typedef enum logic [ROUTE_W-1:0] {
    ROUTE_INT     = 2'b00,
    ROUTE_CRIT    = 2'b01,
    ROUTE_SMI     = 2'b10,
    ROUTE_INT_ALT = 2'b11
  } route_e;

  typedef struct packed {
    logic wrMask;
    logic wrMapA;
    logic wrMapB;
    logic wrCtrl;
  } cfg_strobe_t;
endpackage

// File: rtl/gpic_group.sv
module gpic_group
  import gpic_pkg::*;
(
  input  logic [GROUP_SLOTS-1:0] req,
  input  logic [GROUP_SLOTS-1:0] mask,
  input  logic [MAP_W-1:0]       slotMap,
  input  logic [ROUTE_W-1:0]     route0,
  input  logic [ROUTE_W-1:0]     route1,
  output logic [GROUP_SLOTS-1:0] normPend,
  output logic                   critAny,
  output logic                   smiAny
);
  logic [GROUP_SLOTS-1:0] critVec;
  logic [GROUP_SLOTS-1:0] smiVec;

  for (genvar p = 0; p < GROUP_SLOTS; p++) begin : g_slot
    logic [SLOT_W-1:0]  src;
    logic               act;
    logic [ROUTE_W-1:0] rt;
    assign src = slotMap[p*SLOT_W +: SLOT_W];
    assign act = req[src] & ~mask[src];
    if (p == 0) begin : g_r0
      assign rt = route0;
    end else if (p == 1) begin : g_r1
      assign rt = route1;
    end else begin : g_rn
      assign rt = ROUTE_INT;
    end
    assign normPend[p] = act & ((rt == ROUTE_INT) | (rt == ROUTE_INT_ALT));
    assign critVec[p]  = act & (rt == ROUTE_CRIT);
    assign smiVec[p]   = act & (rt == ROUTE_SMI);
  end

  assign critAny = |critVec;
  assign smiAny  = |smiVec;
endmodule

// File: rtl/gpic_ctrl.sv
module gpic_ctrl
  import gpic_pkg::*;
(
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic               cfgWe,
  input  logic [NUM_SRC-1:0] maskQ,
  input  logic [MAP_W-1:0]   mapAQ,
  input  logic [MAP_W-1:0]   mapBQ,
  input  logic [CTRL_W-1:0]  ctrlQ,
  input  logic [NUM_SRC-1:0] reqRaw,
  output cfg_strobe_t        strobe,
  output logic [CFG_DW-1:0]  cfgRdata
);
  always_comb begin
    strobe        = '0;
    strobe.wrMask = cfgWe && (cfgAddr == ADDR_MASK);
    strobe.wrMapA = cfgWe && (cfgAddr == ADDR_MAPA);
    strobe.wrMapB = cfgWe && (cfgAddr == ADDR_MAPB);
    strobe.wrCtrl = cfgWe && (cfgAddr == ADDR_CTRL);
  end

  always_comb begin
    unique case (cfgAddr)
      ADDR_MASK: cfgRdata = CFG_DW'(maskQ);
      ADDR_MAPA: cfgRdata = mapAQ;
      ADDR_MAPB: cfgRdata = mapBQ;
      ADDR_CTRL: cfgRdata = CFG_DW'(ctrlQ);
      ADDR_PEND: cfgRdata = CFG_DW'(reqRaw);
      default:   cfgRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpic_datapath.sv
module gpic_datapath
  import gpic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  cfg_strobe_t        strobe,
  input  logic [CFG_DW-1:0]  wrData,
  input  logic [NUM_SRC-1:0] reqAll,
  input  logic [MC_SRC-1:0]  mcSrc,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [MAP_W-1:0]   mapAQ,
  output logic [MAP_W-1:0]   mapBQ,
  output logic [CTRL_W-1:0]  ctrlQ,
  output logic               irqNormal,
  output logic               irqCritical,
  output logic               irqSysMgmt,
  output logic [VEC_W-1:0]   irqVector,
  output logic               machineCheck
);
  function automatic logic [MAP_W-1:0] identityMap();
    logic [MAP_W-1:0] m;
    for (int p = 0; p < GROUP_SLOTS; p++) m[p*SLOT_W +: SLOT_W] = SLOT_W'(p);
    return m;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      mapAQ <= identityMap();
      mapBQ <= identityMap();
      ctrlQ <= '0;
    end else begin
      if (strobe.wrMask) maskQ <= wrData[NUM_SRC-1:0];
      if (strobe.wrMapA) mapAQ <= wrData[MAP_W-1:0];
      if (strobe.wrMapB) mapBQ <= wrData[MAP_W-1:0];
      if (strobe.wrCtrl) ctrlQ <= wrData[CTRL_W-1:0];
    end
  end

  logic [MAP_W-1:0]       mapSel   [NUM_GROUPS];
  logic [GROUP_SLOTS-1:0] normPend [NUM_GROUPS];
  logic [NUM_GROUPS-1:0]  critG;
  logic [NUM_GROUPS-1:0]  smiG;

  assign mapSel[0] = mapAQ;
  assign mapSel[1] = mapBQ;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    gpic_group u_grp (
      .req     (reqAll[g*GROUP_SLOTS +: GROUP_SLOTS]),
      .mask    (maskQ[g*GROUP_SLOTS +: GROUP_SLOTS]),
      .slotMap (mapSel[g]),
      .route0  (ctrlQ[ROUTE_LSB + 2*ROUTE_W*g +: ROUTE_W]),
      .route1  (ctrlQ[ROUTE_LSB + 2*ROUTE_W*g + ROUTE_W +: ROUTE_W]),
      .normPend(normPend[g]),
      .critAny (critG[g]),
      .smiAny  (smiG[g])
    );
  end

  // Global rank key: lower wins. Leading group takes even keys; trailing
  // group interleaves (spread) or sits after the whole leading group.
  logic             found;
  logic [KEY_W-1:0] bestKey;
  logic [VEC_W-1:0] bestVec;
  logic [KEY_W-1:0] key;
  logic             isTrail;

  always_comb begin
    found   = 1'b0;
    bestKey = '1;
    bestVec = '0;
    key     = '0;
    isTrail = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      isTrail = ((g == 1) != ctrlQ[LEAD_BIT]);
      for (int p = 0; p < GROUP_SLOTS; p++) begin
        key = KEY_W'(2*p);
        if (isTrail) key = key + (ctrlQ[g] ? KEY_W'(1) : KEY_W'(2*GROUP_SLOTS));
        if (normPend[g][p] && (!found || key < bestKey)) begin
          found   = 1'b1;
          bestKey = key;
          bestVec = VEC_W'(g*GROUP_SLOTS) + VEC_W'(mapSel[g][p*SLOT_W +: SLOT_W]) + VEC_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqNormal    <= 1'b0;
      irqCritical  <= 1'b0;
      irqSysMgmt   <= 1'b0;
      irqVector    <= '0;
      machineCheck <= 1'b0;
    end else begin
      irqNormal    <= found;
      irqCritical  <= |critG;
      irqSysMgmt   <= |smiG;
      irqVector    <= bestVec;
      machineCheck <= |mcSrc;
    end
  end
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import gpic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [GROUP_SLOTS-1:0] srcIntA,
  input  logic [MIX_INT-1:0] srcIntB,
  input  logic [MIX_EXT-1:0] srcExtB,
  input  logic [MC_SRC-1:0]  mcSrc,
  input  logic [CFG_AW-1:0]  cfgAddr,
  input  logic               cfgWe,
  input  logic [CFG_DW-1:0]  cfgWdata,
  output logic [CFG_DW-1:0]  cfgRdata,
  output logic               irqNormal,
  output logic               irqCritical,
  output logic               irqSysMgmt,
  output logic [VEC_W-1:0]   irqVector,
  output logic               machineCheck
);
  logic [NUM_SRC-1:0] reqAll;
  logic [NUM_SRC-1:0] maskQ;
  logic [MAP_W-1:0]   mapAQ;
  logic [MAP_W-1:0]   mapBQ;
  logic [CTRL_W-1:0]  ctrlQ;
  cfg_strobe_t        strobe;

  assign reqAll = {srcExtB, srcIntB, srcIntA};

  gpic_ctrl u_ctrl (
    .cfgAddr (cfgAddr),
    .cfgWe   (cfgWe),
    .maskQ   (maskQ),
    .mapAQ   (mapAQ),
    .mapBQ   (mapBQ),
    .ctrlQ   (ctrlQ),
    .reqRaw  (reqAll),
    .strobe  (strobe),
    .cfgRdata(cfgRdata)
  );

  gpic_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (cfgWdata),
    .reqAll      (reqAll),
    .mcSrc       (mcSrc),
    .maskQ       (maskQ),
    .mapAQ       (mapAQ),
    .mapBQ       (mapBQ),
    .ctrlQ       (ctrlQ),
    .irqNormal   (irqNormal),
    .irqCritical (irqCritical),
    .irqSysMgmt  (irqSysMgmt),
    .irqVector   (irqVector),
    .machineCheck(machineCheck)
  );
endmodule

// File: rtl/grouped_irq_ctrl_chk.sv
module grouped_irq_ctrl_chk
  import gpic_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] reqAll,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [CTRL_W-1:0]  ctrlQ,
  input logic [MC_SRC-1:0]  mcSrc,
  input logic               irqNormal,
  input logic               irqCritical,
  input logic               irqSysMgmt,
  input logic [VEC_W-1:0]   irqVector,
  input logic               machineCheck
);
  logic [NUM_SRC-1:0] reqPrev;
  logic [NUM_SRC-1:0] maskPrev;
  logic [VEC_W-1:0]   vecIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev  <= '0;
      maskPrev <= '1;
    end else begin
      reqPrev  <= reqAll;
      maskPrev <= maskQ;
    end
  end

  assign vecIdx = irqVector - VEC_W'(1);

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |=> !(irqNormal || irqCritical || irqSysMgmt)); // R1
  AST_ROUTE_ALL_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[CTRL_W-1:ROUTE_LSB] == '0) |=> !(irqCritical || irqSysMgmt)); // R2
  AST_VEC_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqNormal == (irqVector != '0)); // R7
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    irqVector <= VEC_W'(NUM_SRC)); // R7
  AST_VEC_SOURCE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    irqNormal |-> (reqPrev[vecIdx[SLOT_W:0]] && !maskPrev[vecIdx[SLOT_W:0]])); // R1
  AST_MC_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (|mcSrc) |=> machineCheck); // R8
  AST_MC_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !(|mcSrc) |=> !machineCheck); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (reqAll == '0) |=> !(irqNormal || irqCritical || irqSysMgmt)); // R9
endmodule

bind grouped_irq_ctrl grouped_irq_ctrl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqAll      (reqAll),
  .maskQ       (maskQ),
  .ctrlQ       (ctrlQ),
  .mcSrc       (mcSrc),
  .irqNormal   (irqNormal),
  .irqCritical (irqCritical),
  .irqSysMgmt  (irqSysMgmt),
  .irqVector   (irqVector),
  .machineCheck(machineCheck)
);

// File: tb/grouped_irq_ctrl_tb.sv
module grouped_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  srcIntA = '0;
  logic [3:0]  srcIntB = '0;
  logic [3:0]  srcExtB = '0;
  logic [3:0]  mcSrc = '0;
  logic [2:0]  cfgAddr = '0;
  logic        cfgWe = 1'b0;
  logic [23:0] cfgWdata = '0;
  logic [23:0] cfgRdata;
  logic        irqNormal, irqCritical, irqSysMgmt, machineCheck;
  logic [4:0]  irqVector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] mMask;
  logic [23:0] mMapA, mMapB;
  logic [10:0] mCtrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  grouped_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .srcIntA(srcIntA), .srcIntB(srcIntB), .srcExtB(srcExtB),
    .mcSrc(mcSrc), .cfgAddr(cfgAddr), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .irqNormal(irqNormal), .irqCritical(irqCritical),
    .irqSysMgmt(irqSysMgmt), .irqVector(irqVector), .machineCheck(machineCheck)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reference: walk the 16 slots in global order built from the rules.
  function automatic logic [7:0] refModel(input logic [15:0] req);
    logic lead, trail, norm, crit, smi;
    logic [4:0] vec;
    lead = mCtrl[2];
    trail = ~lead;
    norm = 0; crit = 0; smi = 0; vec = 0;
    for (int k = 0; k < 16; k++) begin
      int g, p, src;
      logic [1:0] rt;
      logic [23:0] m;
      if (mCtrl[trail]) begin
        g = (k % 2 == 1) ? int'(trail) : int'(lead);
        p = k / 2;
      end else begin
        g = (k < 8) ? int'(lead) : int'(trail);
        p = k % 8;
      end
      m = (g == 0) ? mMapA : mMapB;
      src = g * 8 + int'(m[p*3 +: 3]);
      rt = (p < 2) ? mCtrl[3 + 4*g + 2*p +: 2] : 2'b00;
      if (req[src] && !mMask[src]) begin
        if (rt == 2'b01) crit = 1;
        else if (rt == 2'b10) smi = 1;
        else if (!norm) begin norm = 1; vec = 5'(src + 1); end
      end
    end
    return {smi, crit, norm, vec};
  endfunction

  task automatic cfgWrite(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWdata = d; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    case (a)
      3'd0: mMask = d[15:0];
      3'd1: mMapA = d;
      3'd2: mMapB = d;
      3'd3: mCtrl = d[10:0];
      default: ;
    endcase
  endtask

  task automatic setReq(input logic [15:0] r);
    {srcExtB, srcIntB, srcIntA} = r;
  endtask

  task automatic apply(input string tag, input logic [15:0] r);
    @(negedge clk);
    setReq(r);
    @(negedge clk);
    chk(tag, {24'd0, irqSysMgmt, irqCritical, irqNormal, irqVector}, {24'd0, refModel(r)});
  endtask

  task automatic pairSweep(input string tag);
    for (int i = 0; i < 16; i++)
      for (int j = i; j < 16; j++)
        apply(tag, 16'(1 << i) | 16'(1 << j));
  endtask

  task automatic readChk(input string tag, input logic [2:0] a, input logic [23:0] exp);
    @(negedge clk);
    cfgAddr = a;
    #1;
    chk(tag, {8'd0, cfgRdata}, {8'd0, exp});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    mMask = 16'hFFFF; mCtrl = '0;
    mMapA = 24'o76543210; mMapB = 24'o76543210;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 outputs", {27'd0, irqSysMgmt, irqCritical, irqNormal, machineCheck}, 32'd0);
    chk("R11 vector", {27'd0, irqVector}, 32'd0);
    rstN = 1'b1;
    readChk("R1 mask reset", 3'd0, 24'h00FFFF);
    readChk("R3 mapA reset", 3'd1, 24'o76543210);
    readChk("R3 mapB reset", 3'd2, 24'o76543210);
    readChk("R11 ctrl reset", 3'd3, 24'd0);

    // R1: all masked, all requesting
    apply("R1 all masked", 16'hFFFF);
    // R10: pending shows raw requests
    readChk("R10 pending raw", 3'd4, 24'h00FFFF);
    readChk("R10 unmapped 5", 3'd5, 24'd0);
    readChk("R10 unmapped 7", 3'd7, 24'd0);

    // R9: config write latency, request held pending
    @(negedge clk);
    setReq(16'h0020);
    cfgAddr = 3'd0; cfgWdata = 24'h0; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0; mMask = 16'h0;
    chk("R9 old value one edge after write", {31'd0, irqNormal}, 32'd0);
    @(negedge clk);
    chk("R9 new value two edges after write", {27'd0, irqVector}, 32'd6);
    readChk("R10 mask readback", 3'd0, 24'd0);

    // R9: request latency
    @(negedge clk);
    setReq(16'h0000);
    chk("R9 before edge", {31'd0, irqNormal}, 32'd1);
    @(negedge clk);
    chk("R9 after edge", {31'd0, irqNormal}, 32'd0);

    // R5 R6 R7: all scheme/lead combinations, identity maps
    for (int c = 0; c < 8; c++) begin
      cfgWrite(3'd3, 24'(c));
      pairSweep("R5 R6 R7 scheme/lead");
    end
    readChk("R10 ctrl readback", 3'd3, 24'd7);

    // R2: routing of slots 0 and 1
    cfgWrite(3'd3, {13'd0, 2'b11, 2'b10, 2'b10, 2'b01, 3'b010});
    pairSweep("R2 routing mix");
    cfgWrite(3'd3, {13'd0, 2'b01, 2'b01, 2'b10, 2'b10, 3'b101});
    pairSweep("R2 routing swap");
    apply("R2 crit only", 16'h0100);

    // R3 R4: permuted maps
    cfgWrite(3'd1, 24'o01234567);
    cfgWrite(3'd2, 24'o21076543);
    readChk("R3 mapB readback", 3'd2, 24'o21076543);
    cfgWrite(3'd3, 24'd0);
    pairSweep("R3 R4 maps lead A");
    cfgWrite(3'd3, {13'd0, 2'b00, 2'b01, 2'b10, 2'b00, 3'b111});
    pairSweep("R3 R4 maps lead B spread");

    // R1: random masks and requests
    lfsr = 16'hACE1;
    for (int n = 0; n < 64; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cfgWrite(3'd0, {8'd0, lfsr});
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply("R1 random mask", lfsr);
    end

    // R8: machine check is unmaskable
    cfgWrite(3'd0, 24'h00FFFF);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); mcSrc = 4'(1 << b);
      @(negedge clk); chk("R8 mc single", {31'd0, machineCheck}, 32'd1);
    end
    @(negedge clk); mcSrc = 4'd0;
    @(negedge clk); chk("R8 mc idle", {31'd0, machineCheck}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule